// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block holds the on/off pattern for a 12-row by 8-column analog crosspoint matrix. Each of its 96 one-bit cells drives one switch: a 1 closes the switch, a 0 opens it. A controller picks a cell with a 4-bit row field and a 3-bit column field. It presents the wanted level on the data input and raises chip select and strobe. While both are high, the addressed cell is transparent and follows the data input. When strobe falls, the cell keeps the last level it saw. Every other cell keeps its value. Several of these blocks can share one address, data and strobe bus and be told apart by chip select.

The strobe, chip select, data and address inputs are asynchronous to the system clock. Each passes through a two-stage synchronizer, and the addressed cell is then rewritten on every clock in which the synchronized enable is high. This gives the behaviour of a bank of resettable transparent latches using only clocked flops. A global reset input clears every cell at once. It does not wait for a clock, and it wins over chip select, strobe and any write in progress.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: After reset is released, and before any write, all 96 bits of `xpt_state` are 0.
- R2: The cell at row r (row_addr, 0..11) and column c (col_addr, 0..7) is bit r*8+c of `xpt_state`. Bit 0 is row 0, column 0, and bit 95 is row 11, column 7.
- R3: With reset low, a write cycle in which data_in is 1 on the last enabled cycle sets the addressed bit to 1. A write cycle in which data_in is 0 there clears the bit to 0.
- R4: A strobe pulse while chip select is low changes no bit of `xpt_state`.
- R5: While chip select and strobe are both high, the addressed bit follows data_in and tracks each change of data_in.
- R6: The value held after strobe falls is the data_in level that was present together with the last high strobe. Changes of data_in after strobe has fallen have no effect.
- R7: A write changes only the addressed bit. All other 95 bits keep their values.
- R8: Reset high clears all 96 bits at once, without waiting for a clock edge, whatever the state of chip select, strobe and data_in.
- R9: While reset is high, no bit can be set, even if chip select and strobe are high.
- R10: Row codes 12 to 15 select no cell. A strobe with such a row code leaves all bits unchanged.
- R11: When a change of data_in is made between clock edges while the enable is active, it appears on the addressed bit after the third rising clock edge, and not after the second.
- R12: If the address changes while strobe and chip select stay high, the newly addressed cell becomes the transparent one. The cell addressed before keeps the last value it received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset that clears all cells |
| row_addr | input | 4 | Row field of the cell address (0..11 valid) |
| col_addr | input | 3 | Column field of the cell address |
| data_in | input | 1 | Level written into the addressed cell |
| cs | input | 1 | Active-high chip select |
| strobe | input | 1 | Active-high write strobe; the cell holds its value when it falls |
| xpt_state | output | 96 | Switch state vector, bit r*8+c for row r and column c |

## Verification
The two functions that can fall in the same cycle are the global clear and a write in progress. The bench also covers the fall of strobe together with a change of data_in. In the first case, reset is raised between clock edges while chip select, strobe and data_in=1 are held on a selected cell. The output is sampled right away to confirm an asynchronous clear, and again several clocks later to confirm that no write got through while reset was high. In the second case, strobe and data_in fall at the same instant. The held value must be the level that was present with the last high strobe, and the bench's reference model predicts exactly that.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  localparam int unsigned XPT_ROWS   = 12;
  localparam int unsigned XPT_COLS   = 8;
  localparam int unsigned XPT_ROW_AW = $clog2(XPT_ROWS);
  localparam int unsigned XPT_COL_AW = $clog2(XPT_COLS);
  localparam int unsigned XPT_CELLS  = XPT_ROWS * XPT_COLS;
  localparam int unsigned XPT_IDX_W  = $clog2(XPT_CELLS);

  // Flat position of a crosspoint: row-major, columns fastest.
  function automatic int unsigned xpt_flat_index(input int unsigned row,
                                                 input int unsigned col,
                                                 input int unsigned cols);
    return row * cols + col;
  endfunction

  // A row code names a real row only below the row count.
  function automatic bit xpt_row_ok(input int unsigned row,
                                    input int unsigned rows);
    return row < rows;
  endfunction

  // A column code names a real column only below the column count.
  function automatic bit xpt_col_ok(input int unsigned col,
                                    input int unsigned cols);
    return col < cols;
  endfunction

endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or posedge rst) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge rst) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/xpt_decode.sv
module xpt_decode
  import xpt_pkg::*;
#(
  parameter int unsigned ROWS   = XPT_ROWS,
  parameter int unsigned COLS   = XPT_COLS,
  parameter int unsigned ROW_AW = XPT_ROW_AW,
  parameter int unsigned COL_AW = XPT_COL_AW,
  localparam int unsigned CELLS = ROWS * COLS,
  localparam int unsigned IDX_W = $clog2(CELLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [ROW_AW-1:0] row_addr,
  input  logic [COL_AW-1:0] col_addr,
  output logic [CELLS-1:0]  wr_sel,
  output logic              addr_ok,
  output logic [IDX_W-1:0]  wr_idx
);

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
        assign wr_sel[r*COLS + c] = enable
                                    && (row_addr == ROW_AW'(r))
                                    && (col_addr == COL_AW'(c));
      end
    end
  endgenerate

  assign addr_ok = xpt_row_ok(int'(row_addr), ROWS)
                && xpt_col_ok(int'(col_addr), COLS);
  assign wr_idx  = IDX_W'(xpt_flat_index(int'(row_addr), int'(col_addr), COLS));

  // R7: at most one cell is opened for writing in any cycle.
  p_one_cell_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));

  // R10: an out-of-range row or column never selects a cell.
  p_bad_row_silent_r10: assert property (@(posedge clk) disable iff (rst)
    (|wr_sel) |-> addr_ok);

endmodule

// File: rtl/xpt_cell_array.sv
module xpt_cell_array #(
  parameter int unsigned CELLS = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CELLS-1:0] wr_sel,
  input  logic             wr_data,
  output logic [CELLS-1:0] cells
);

  generate
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
      always_ff @(posedge clk or posedge rst) begin
        if (rst)            cells[i] <= 1'b0;
        else if (wr_sel[i]) cells[i] <= wr_data;
      end
    end
  endgenerate

  // R7: bits that were not selected keep their previous value.
  p_unselected_keep_r7: assert property (@(posedge clk) disable iff (rst)
    ((cells ^ $past(cells)) & ~$past(wr_sel)) == '0);

  // R9: the cycle after a reset cycle still shows an all-clear array.
  p_reset_empties_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cells == '0));

endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem
  import xpt_pkg::*;
#(
  parameter int unsigned ROWS        = XPT_ROWS,
  parameter int unsigned COLS        = XPT_COLS,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ROW_AW = $clog2(ROWS),
  localparam int unsigned COL_AW = $clog2(COLS),
  localparam int unsigned CELLS  = ROWS * COLS,
  localparam int unsigned IDX_W  = $clog2(CELLS),
  localparam int unsigned BUS_W  = 3 + ROW_AW + COL_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROW_AW-1:0] row_addr,
  input  logic [COL_AW-1:0] col_addr,
  input  logic              data_in,
  input  logic              cs,
  input  logic              strobe,
  output logic [CELLS-1:0]  xpt_state
);

  logic [BUS_W-1:0]  raw_bus;
  logic [BUS_W-1:0]  sync_bus;
  logic              cs_s;
  logic              stb_s;
  logic              data_s;
  logic [ROW_AW-1:0] row_s;
  logic [COL_AW-1:0] col_s;

  // Named internal events for the checks below.
  logic              win_open;
  logic              strobe_close;
  logic              stb_q;
  logic [CELLS-1:0]  wr_sel;
  logic              addr_ok;
  logic [IDX_W-1:0]  wr_idx;

  assign raw_bus = {cs, strobe, data_in, row_addr, col_addr};

  xpt_sync #(
    .WIDTH (BUS_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(raw_bus),
    .q_sync (sync_bus)
  );

  assign {cs_s, stb_s, data_s, row_s, col_s} = sync_bus;

  assign win_open = cs_s && stb_s;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= stb_s;
  end

  assign strobe_close = stb_q && !stb_s;

  xpt_decode #(
    .ROWS  (ROWS),
    .COLS  (COLS),
    .ROW_AW(ROW_AW),
    .COL_AW(COL_AW)
  ) u_decode (
    .clk     (clk),
    .rst     (rst),
    .enable  (win_open),
    .row_addr(row_s),
    .col_addr(col_s),
    .wr_sel  (wr_sel),
    .addr_ok (addr_ok),
    .wr_idx  (wr_idx)
  );

  xpt_cell_array #(
    .CELLS(CELLS)
  ) u_cells (
    .clk    (clk),
    .rst    (rst),
    .wr_sel (wr_sel),
    .wr_data(data_s),
    .cells  (xpt_state)
  );

  // R5: an open window on a valid cell copies the synchronized data.
  p_follow_data_r5: assert property (@(posedge clk) disable iff (rst)
    (win_open && addr_ok) |=> (xpt_state[$past(wr_idx)] == $past(data_s)));

  // R4 / R6: with the window shut, nothing moves.
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !win_open |=> $stable(xpt_state));

  // R6: the cycle after strobe closes, the held pattern is unchanged.
  p_close_hold_r6: assert property (@(posedge clk) disable iff (rst)
    strobe_close |=> $stable(xpt_state));

  // R10: a window on an out-of-range address leaves everything alone.
  p_bad_row_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (win_open && !addr_ok) |=> $stable(xpt_state));

  // R8: reset holds the output cleared on every sampled edge.
  always @(posedge clk) begin
    if (rst) begin
      p_reset_clear_r8: assert (xpt_state == '0);
    end
  end

endmodule

// File: tb/xpt_ctrl_mem_tb.sv
module xpt_ctrl_mem_tb;

  localparam int unsigned NR = 12;
  localparam int unsigned NC = 8;
  localparam int unsigned NB = NR * NC;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    row_addr = '0;
  logic [2:0]    col_addr = '0;
  logic          data_in = 1'b0;
  logic          cs = 1'b0;
  logic          strobe = 1'b0;
  logic [NB-1:0] xpt_state;

  logic [NB-1:0] model = '0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5ns clk = ~clk;

  xpt_ctrl_mem u_dut (
    .clk      (clk),
    .rst      (rst),
    .row_addr (row_addr),
    .col_addr (col_addr),
    .data_in  (data_in),
    .cs       (cs),
    .strobe   (strobe),
    .xpt_state(xpt_state)
  );

  // Bit position: the row code and the column code packed side by side.
  function automatic int bit_of(input logic [3:0] r, input logic [2:0] c);
    logic [6:0] p;
    p = {r, c};
    return int'(p);
  endfunction

  task automatic check_vec(input string tag, input logic [NB-1:0] exp);
    n_cmp++;
    if (xpt_state !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, xpt_state, exp);
    end
  endtask

  task automatic check_bit(input string tag, input int idx, input logic exp);
    n_cmp++;
    if (xpt_state[idx] !== exp) begin
      n_bad++;
      $display("FAIL %s: bit %0d got %b expected %b", tag, idx, xpt_state[idx], exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Whole write cycle: set up, pulse strobe, settle.
  task automatic do_write(input logic [3:0] r, input logic [2:0] c,
                          input logic d, input logic sel, input int width);
    @(negedge clk);
    row_addr = r; col_addr = c; data_in = d; cs = sel;
    @(negedge clk);
    strobe = 1'b1;
    cycles(width);
    strobe = 1'b0;
    cycles(4);
    cs = 1'b0;
    if (sel && r < 4'd12) model[bit_of(r, c)] = d;
  endtask

  initial begin
    cycles(3);
    rst = 1'b0;
    cycles(2);
    check_vec("R1 reset state", model);

    // R2 / R3: corner positions.
    do_write(4'd0, 3'd0, 1'b1, 1'b1, 2);
    check_bit("R2 row0 col0 -> bit0", 0, 1'b1);
    do_write(4'd11, 3'd7, 1'b1, 1'b1, 2);
    check_bit("R2 row11 col7 -> bit95", 95, 1'b1);
    do_write(4'd3, 3'd5, 1'b1, 1'b1, 1);
    check_vec("R2 row3 col5 -> bit29", model);
    check_bit("R2 bit29", 29, 1'b1);
    do_write(4'd0, 3'd0, 1'b0, 1'b1, 3);
    check_bit("R3 clear", 0, 1'b0);
    check_vec("R7 others kept", model);

    // R4: chip select low.
    do_write(4'd5, 3'd2, 1'b1, 1'b0, 3);
    check_vec("R4 cs low no write", model);

    // R10: invalid row codes.
    for (int r = 12; r < 16; r++) begin
      do_write(4'(r), 3'd1, 1'b1, 1'b1, 2);
      check_vec("R10 invalid row ignored", model);
    end

    // R5 / R11 / R6: transparency, latency and capture at strobe fall.
    @(negedge clk);
    row_addr = 4'd7; col_addr = 3'd3; cs = 1'b1; data_in = 1'b1; strobe = 1'b1;
    cycles(5);
    check_bit("R5 follows 1", bit_of(4'd7, 3'd3), 1'b1);
    data_in = 1'b0;
    cycles(2);
    check_bit("R11 not after two edges", bit_of(4'd7, 3'd3), 1'b1);
    cycles(1);
    check_bit("R11 after three edges", bit_of(4'd7, 3'd3), 1'b0);
    data_in = 1'b1;
    cycles(4);
    check_bit("R5 follows back to 1", bit_of(4'd7, 3'd3), 1'b1);
    strobe = 1'b0; data_in = 1'b0;
    cycles(5);
    check_bit("R6 held at strobe fall", bit_of(4'd7, 3'd3), 1'b1);
    data_in = 1'b1; cycles(2); data_in = 1'b0;
    cycles(4);
    check_bit("R6 later data ignored", bit_of(4'd7, 3'd3), 1'b1);
    model[bit_of(4'd7, 3'd3)] = 1'b1;
    check_vec("R7 transparency touched one bit", model);
    cs = 1'b0;

    // R12: address moves inside the window.
    @(negedge clk);
    row_addr = 4'd9; col_addr = 3'd0; cs = 1'b1; data_in = 1'b1; strobe = 1'b1;
    cycles(4);
    row_addr = 4'd9; col_addr = 3'd6;
    cycles(4);
    data_in = 1'b0;
    cycles(4);
    check_bit("R12 old cell keeps value", bit_of(4'd9, 3'd0), 1'b1);
    check_bit("R12 new cell transparent", bit_of(4'd9, 3'd6), 1'b0);
    strobe = 1'b0;
    cycles(4);
    cs = 1'b0;
    model[bit_of(4'd9, 3'd0)] = 1'b1;
    model[bit_of(4'd9, 3'd6)] = 1'b0;
    check_vec("R12 whole vector", model);

    // Random traffic.
    for (int k = 0; k < 200; k++) begin
      logic [3:0] r;
      logic [2:0] c;
      logic d, s;
      r = 4'($urandom_range(0, 15));
      c = 3'($urandom_range(0, 7));
      d = 1'($urandom_range(0, 1));
      s = ($urandom_range(0, 7) != 0);
      do_write(r, c, d, s, int'($urandom_range(1, 4)));
      check_vec("R3 R7 random write", model);
    end

    // R8 / R9: reset during an active write.
    @(negedge clk);
    row_addr = 4'd2; col_addr = 3'd4; cs = 1'b1; data_in = 1'b1; strobe = 1'b1;
    cycles(4);
    #2ns rst = 1'b1;
    #1ns;
    model = '0;
    check_vec("R8 asynchronous clear", model);
    cycles(4);
    check_vec("R9 no write under reset", model);
    strobe = 1'b0; cs = 1'b0;
    cycles(3);
    rst = 1'b0;
    cycles(4);
    check_vec("R8 clear after release", model);
    do_write(4'd2, 3'd4, 1'b1, 1'b1, 2);
    check_vec("R3 write after reset", model);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1500us;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule